// File: doc/BRIEF.md
# Length-Limited Vector Byte Loader

This block fills a 128-bit vector with a variable number of bytes fetched one at a time from byte-addressed memory. A command supplies a start address, a 64-bit length operand and two placement flags. The byte count is taken from the top byte of the operand. Counts above sixteen are treated as sixteen, and a count of zero fetches nothing. The vector is cleared when the command is accepted, so every element that no fetched byte lands on reads as zero.

Bytes normally fill the vector upward from element 0. When the little-endian flag is set and the left-justify flag is clear, they fill downward from element 15 instead. The memory side issues one single-cycle request at a time and waits for its read-valid before it issues the next, stepping the address by one each time. A single-cycle done pulse marks the end of the command, and the finished vector stays on the result port until the next accepted command.

The `LEN_OP_W` parameter sets the operand width. With 64 the count comes from bits 63:56. With 32 it comes from bits 31:24.

Top module: `vbl_loader`

## Requirements
- R1: The byte count is `len_op_i[63:56]` (top byte of the operand). The lower 56 bits have no effect on the number of requests or on the result.
- R2: A command whose count is 0 issues no memory request. `done_o` rises in the cycle after the command is accepted, and `result_o` is all zeros.
- R3: A count of 16 or more (up to 255) issues exactly 16 requests.
- R4: Accepting a command clears the whole vector. Elements that receive no fetched byte read zero, including bits left from an earlier command.
- R5: Element e occupies `result_o[127-8e : 120-8e]`. In ascending placement the k-th fetched byte (k from 0) goes to element k.
- R6: With `little_i`=1 and `left_just_i`=0, the k-th fetched byte goes to element 15-k.
- R7: With `left_just_i`=1, placement is ascending whatever `little_i` is.
- R8: Request k carries address `addr_i + k` modulo 2^64, so addresses wrap from all-ones to zero.
- R9: `mem_req_o` is a one-cycle pulse. After a request, no further request is issued until `mem_rvalid_i` has been seen, and the next request then follows in the very next cycle.
- R10: `done_o` is high for exactly one cycle per command. `result_o` stays stable after it until a new command is accepted.
- R11: `start_i` raised while a command is in progress is ignored. The running command's request count and result are unchanged.
- R12: After reset `mem_req_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| addr_i | input | 64 | Address of the first byte |
| len_op_i | input | 64 | Length operand; its top byte is the count |
| little_i | input | 1 | Little-endian placement select |
| left_just_i | input | 1 | Forces ascending placement |
| mem_req_o | output | 1 | One-cycle byte read request |
| mem_addr_o | output | 64 | Address of the requested byte |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| result_o | output | 128 | Loaded vector, element 0 in the top byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory returns exactly one `mem_rvalid_i` for each request, never raises it unsolicited, and never raises it in the cycle of the request itself. The bench memory model enforces this. It latches each request on the falling edge and raises read-valid for one cycle after a programmable latency of zero to two cycles. It then goes quiet until the next request. The address checks assume the memory answers every request.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
    localparam int VEC_BYTES = 16;
    localparam int BYTE_W    = 8;
    localparam int VEC_W     = VEC_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(VEC_BYTES + 1);
    localparam int LANE_W    = $clog2(VEC_BYTES);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        cnt_t nbytes;
        logic reverse;
    } load_cmd_t;

    // Saturate the raw count byte at the vector size.
    function automatic cnt_t clamp_len(input logic [BYTE_W-1:0] raw);
        if (raw >= BYTE_W'(VEC_BYTES))
            return cnt_t'(VEC_BYTES);
        return cnt_t'(raw);
    endfunction

    // Vector lane targeted by the k-th fetched byte.
    function automatic lane_t lane_of(input cnt_t k, input logic reverse);
        if (reverse)
            return lane_t'(VEC_BYTES - 1) - k[LANE_W-1:0];
        return k[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/vbl_len_decode.sv
module vbl_len_decode
    import vbl_pkg::*;
#(
    parameter int LEN_OP_W = 64
) (
    input  logic [LEN_OP_W-1:0] len_op_i,
    input  logic                little_i,
    input  logic                left_just_i,
    output load_cmd_t           cmd_o
);
    localparam int LEN_MSB = LEN_OP_W - 1;

    logic [BYTE_W-1:0] raw_len;

    generate
        if (LEN_OP_W >= BYTE_W) begin : g_top_byte
            assign raw_len = len_op_i[LEN_MSB -: BYTE_W];
        end else begin : g_narrow
            assign raw_len = BYTE_W'(len_op_i);
        end
    endgenerate

    always_comb begin
        cmd_o.nbytes  = clamp_len(raw_len);
        cmd_o.reverse = little_i & ~left_just_i;
    end
endmodule

// File: rtl/vbl_byte_place.sv
module vbl_byte_place
    import vbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              wr_i,
    input  cnt_t              idx_i,
    input  logic              reverse_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [VEC_W-1:0]  vec_o
);
    lane_t lane_sel;
    logic [BYTE_W-1:0] lane_q [VEC_BYTES];

    assign lane_sel = lane_of(idx_i, reverse_i);

    generate
        for (genvar e = 0; e < VEC_BYTES; e++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst || clear_i)
                    lane_q[e] <= '0;
                else if (wr_i && lane_sel == lane_t'(e))
                    lane_q[e] <= data_i;
            end
            assign vec_o[VEC_W-1-BYTE_W*e -: BYTE_W] = lane_q[e];
        end
    endgenerate

    // R4: a clear leaves the whole vector at zero on the next cycle
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (vec_o == '0));

    // R5: a write with no clear changes only the selected lane
    p_write_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !clear_i) |=> ($countones(vec_o ^ $past(vec_o)) <= BYTE_W));
endmodule

// File: rtl/vbl_seq.sv
module vbl_seq
    import vbl_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  load_cmd_t         cmd_i,
    input  logic              mem_rvalid_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              clear_o,
    output logic              wr_o,
    output cnt_t              idx_o,
    output logic              reverse_o,
    output logic              done_o
);
    seq_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    cnt_t              cnt_q;
    cnt_t              n_q;
    logic              rev_q;
    cnt_t              cnt_nxt;
    logic              accept;
    logic              last_byte;

    assign cnt_nxt   = cnt_q + cnt_t'(1);
    assign accept    = (st_q == ST_IDLE) && start_i;
    assign last_byte = (cnt_nxt == n_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            cnt_q  <= '0;
            n_q    <= '0;
            rev_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    addr_q <= addr_i;
                    n_q    <= cmd_i.nbytes;
                    rev_q  <= cmd_i.reverse;
                    cnt_q  <= '0;
                    st_q   <= (cmd_i.nbytes == '0) ? ST_DONE : ST_REQ;
                end
                ST_REQ:  st_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid_i) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    cnt_q  <= cnt_nxt;
                    st_q   <= last_byte ? ST_DONE : ST_REQ;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o  = (st_q == ST_REQ);
        mem_addr_o = addr_q;
        clear_o    = accept;
        wr_o       = (st_q == ST_WAIT) && mem_rvalid_i;
        idx_o      = cnt_q;
        reverse_o  = rev_q;
        done_o     = (st_q == ST_DONE);
    end

    // R9: a request lasts one cycle
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R9: a non-final response is followed at once by the next request
    p_next_req_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && mem_rvalid_i && !last_byte) |=> mem_req_o);

    // R8: successive requests step the address by one
    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && mem_rvalid_i && !last_byte)
        |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: a zero count goes straight to completion with no request
    p_zero_len_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_i.nbytes == '0) |=> (done_o && !mem_req_o));

    // R11: a start while busy does not disturb the latched count
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && start_i) |=> (n_q == $past(n_q)));

    // R3: progress never passes the clamped count
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= n_q) && (n_q <= cnt_t'(VEC_BYTES)));
endmodule

// File: rtl/vbl_loader.sv
module vbl_loader
    import vbl_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int LEN_OP_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [LEN_OP_W-1:0] len_op_i,
    input  logic                little_i,
    input  logic                left_just_i,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic                mem_rvalid_i,
    input  logic [BYTE_W-1:0]   mem_rdata_i,
    output logic [VEC_W-1:0]    result_o,
    output logic                done_o
);
    load_cmd_t cmd;
    logic      clear;
    logic      wr;
    cnt_t      idx;
    logic      reverse;

    vbl_len_decode #(.LEN_OP_W(LEN_OP_W)) u_decode (
        .len_op_i    (len_op_i),
        .little_i    (little_i),
        .left_just_i (left_just_i),
        .cmd_o       (cmd)
    );

    vbl_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .addr_i       (addr_i),
        .cmd_i        (cmd),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .clear_o      (clear),
        .wr_o         (wr),
        .idx_o        (idx),
        .reverse_o    (reverse),
        .done_o       (done_o)
    );

    vbl_byte_place u_place (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clear),
        .wr_i      (wr),
        .idx_i     (idx),
        .reverse_i (reverse),
        .data_i    (mem_rdata_i),
        .vec_o     (result_o)
    );

    // R12: outputs are quiet in the cycle after reset
    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |=> (!mem_req_o && !done_o && result_o == '0));
endmodule

// File: tb/vbl_loader_tb.sv
module vbl_loader_tb;
    localparam int N_VEC = 8;

    localparam logic [63:0] T_ADDR [N_VEC] = '{
        64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000,
        64'h0000_0000_0000_1000, 64'h0000_0000_0000_2040,
        64'h0000_0000_0000_2040, 64'h0000_0000_0000_30F0,
        64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0077};
    localparam logic [63:0] T_OP [N_VEC] = '{
        64'h0E00_0000_0000_0000, 64'h0E00_0000_0000_0000,
        64'h0E00_0000_0000_0000, 64'h1000_0000_0000_0000,
        64'hFF00_0000_0000_0000, 64'h03FF_FFFF_FFFF_FFFF,
        64'h0400_0000_0000_0000, 64'h0100_0000_0000_0000};
    localparam logic [N_VEC-1:0] T_LE = 8'b1011_0110;
    localparam logic [N_VEC-1:0] T_LJ = 8'b0000_0100;
    localparam int T_LAT [N_VEC] = '{0, 0, 1, 1, 2, 0, 2, 1};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [63:0]  addr = '0;
    logic [63:0]  len_op = '0;
    logic         little = 1'b0;
    logic         ljust = 1'b0;
    logic         mem_req;
    logic [63:0]  mem_addr;
    logic         mem_rvalid = 1'b0;
    logic [7:0]   mem_rdata = '0;
    logic [127:0] result;
    logic         done;

    int tests = 0;
    int fails = 0;

    bit          pend = 1'b0;
    int          lat_left = 0;
    int          cur_lat = 0;
    int          req_cnt = 0;
    int          addr_err = 0;
    logic [63:0] exp_base = '0;
    logic [63:0] req_addr = '0;

    always #4 clk = ~clk;

    vbl_loader u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .addr_i       (addr),
        .len_op_i     (len_op),
        .little_i     (little),
        .left_just_i  (ljust),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .result_o     (result),
        .done_o       (done)
    );

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return (a[7:0] * 8'd13) ^ 8'h6B;
    endfunction

    function automatic int count_of(input logic [63:0] op);
        int n = int'(op[63:56]);
        return (n > 16) ? 16 : n;
    endfunction

    function automatic logic [127:0] expect_vec(input logic [63:0] a, input logic [63:0] op,
                                                input bit le, input bit lj);
        logic [127:0] v = '0;
        int n = count_of(op);
        for (int k = 0; k < n; k++) begin
            int e = (le && !lj) ? 15 - k : k;
            v[127 - 8*e -: 8] = mem_byte(a + 64'(k));
        end
        return v;
    endfunction

    // memory model: one response per request, after cur_lat idle cycles
    always @(negedge clk) begin
        if (rst) begin
            pend = 1'b0;
            mem_rvalid = 1'b0;
        end else if (pend) begin
            if (lat_left == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem_byte(req_addr);
                pend = 1'b0;
            end else begin
                lat_left = lat_left - 1;
                mem_rvalid = 1'b0;
            end
        end else begin
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (mem_addr != exp_base + 64'(req_cnt)) addr_err = addr_err + 1;
                req_cnt = req_cnt + 1;
                req_addr = mem_addr;
                pend = 1'b1;
                lat_left = cur_lat;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        int guard = 0;
        ok = 1'b1;
        while (!done) begin
            @(negedge clk);
            guard++;
            if (guard > 200) begin
                ok = 1'b0;
                break;
            end
        end
    endtask

    task automatic issue(input logic [63:0] a, input logic [63:0] op, input bit le,
                         input bit lj, input int lat);
        @(negedge clk);
        exp_base = a;
        req_cnt = 0;
        addr_err = 0;
        cur_lat = lat;
        addr = a;
        len_op = op;
        little = le;
        ljust = lj;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [127:0] exp_v;
        logic [127:0] got;
        bit ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(result == '0, "R12 result", result, '0);
        check(!done, "R12 done", 128'(done), 0);
        check(!mem_req, "R12 req", 128'(mem_req), 0);

        // table walk: R1 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < N_VEC; i++) begin
            issue(T_ADDR[i], T_OP[i], T_LE[i], T_LJ[i], T_LAT[i]);
            wait_done(ok);
            check(ok, "R9 completion", 128'(ok), 1);
            exp_v = expect_vec(T_ADDR[i], T_OP[i], T_LE[i], T_LJ[i]);
            check(result == exp_v, "R1/R4/R5/R6/R7 result", result, exp_v);
            check(req_cnt == count_of(T_OP[i]), "R1/R3 requests", 128'(req_cnt),
                  128'(count_of(T_OP[i])));
            check(addr_err == 0, "R8 addresses", 128'(addr_err), 0);
            got = result;
            @(negedge clk);
            // R10: single pulse, result held
            check(!done, "R10 done pulse", 128'(done), 0);
            check(result == got, "R10 result held", result, got);
        end

        // R2: zero count, result cleared from the earlier nonzero vector
        issue(64'h0000_0000_0000_5000, 64'h00FF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 0);
        check(done, "R2 done next cycle", 128'(done), 1);
        check(result == '0, "R2/R4 zero result", result, '0);
        @(negedge clk);
        check(req_cnt == 0, "R2 no requests", 128'(req_cnt), 0);

        // R11: start while busy is ignored
        issue(64'h0000_0000_0000_6000, 64'h0500_0000_0000_0000, 1'b0, 1'b0, 2);
        @(negedge clk);
        addr = 64'h0000_0000_0000_7000;
        len_op = 64'h0200_0000_0000_0000;
        little = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        exp_v = expect_vec(64'h0000_0000_0000_6000, 64'h0500_0000_0000_0000, 1'b0, 1'b0);
        check(result == exp_v, "R11 result", result, exp_v);
        check(req_cnt == 5, "R11 requests", 128'(req_cnt), 5);
        check(addr_err == 0, "R11 addresses", 128'(addr_err), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule